// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

The block gathers eight interrupt request lines and forwards the most urgent one to a processor. It has a byte-wide command port and a byte-wide data port, chosen by one address bit. It keeps three registers. The pending register records request lines that have risen. The service register records lines whose handlers are running. The mask register blocks individual lines. Line 0 has the highest priority, and a pending line interrupts only if it outranks everything already in service.

Software brings the block up with an initialization sequence of up to four words. A command word with bit 4 set opens the sequence. The data port then takes a vector base, an optional cascade word and an optional mode word. The mode word can select automatic end of interrupt. Once the sequence is complete, the data port carries the mask. Command words with bit 4 clear either retire one service bit or choose which register a command-port read returns.

When the processor pulses acknowledge, the block returns the vector of the winning line on the following cycle. If no line is eligible, it returns the vector of line 7 and changes no service bit.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the mask reads 0xFF, a command-port read returns the pending register (all zero), int_o is low and vector_valid_o is low.
- R2: A command write with bit 4 set starts initialization. It clears the service register, sets reads back to the pending register and clears automatic EOI. The next data writes are taken in order: the vector base; then a cascade word, skipped if bit 1 of the start word was 1; then a mode word, taken only if bit 0 of the start word was 1. The mask does not change during the sequence.
- R3: Outside initialization, a data write loads the mask, and a data read returns the last mask written.
- R4: Pending bit n sets at the first clock where req_i[n] is seen high after being low. It clears while req_i[n] is low.
- R5: int_o is high exactly when the lowest-numbered pending, unmasked line has a lower index than every set service bit (or no service bit is set).
- R6: Acknowledge is a one-cycle pulse on inta_i. In the next cycle vector_valid_o is high and vector_o holds base+n modulo 256, where n is the winning line. Pending bit n clears. In normal mode service bit n sets.
- R7: When bit 1 of the mode word is 1 (automatic EOI), an acknowledge sets no service bit.
- R8: A command write whose bits 7:5 are 011 and bits 4:3 are 00 clears service bit [2:0] and no other bit.
- R9: Any other command write with bits 4:3 at 00 leaves the service register unchanged.
- R10: A command write with bit 4 at 0 and bit 3 at 1 selects the register that command-port reads return: bits 1:0 at 11 select the service register, 10 select the pending register, and any other value keeps the current choice.
- R11: An acknowledge while int_o is low returns base+7, even when line 7 is masked, and leaves the service and pending registers unchanged.
- R12: When an acknowledge and a specific EOI fall in the same cycle, the acknowledge is judged on the service register as it stood before the EOI, and both updates take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the selected port |
| addr_i | input | 1 | Port select: 0 command, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected port (combinational) |
| req_i | input | 8 | Interrupt request lines |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt line to the processor |
| vector_o | output | 8 | Vector of the acknowledged line |
| vector_valid_o | output | 1 | High for the cycle after an acknowledge |

## Verification
An acknowledge and a specific EOI can land on the same clock edge. Both of them touch the service register, and the acknowledge also reads it to pick a winner. The bench sets up line 2 in service with line 5 pending and therefore blocked. It then drives the acknowledge together with the EOI for line 2 in the same cycle. The bench expects the spurious vector, because the decision was made before the EOI took effect. It also expects the service register to read empty afterwards, and int_o to rise at once for line 5.

// File: rtl/irq_ctrl8_pkg.sv
package irq_ctrl8_pkg;
  localparam int NumLines = 8;
  localparam int DataW    = 8;

  typedef enum logic [1:0] {
    INIT_IDLE,
    INIT_BASE,
    INIT_CASC,
    INIT_MODE
  } init_st_e;

  localparam int       CmdInitBit   = 4;
  localparam int       CmdSelBit    = 3;
  localparam int       StartSnglBit = 1;
  localparam int       StartModeBit = 0;
  localparam int       ModeAeoiBit  = 1;
  localparam logic [2:0] EoiSpecific = 3'b011;
  localparam logic [1:0] SelPending  = 2'b10;
  localparam logic [1:0] SelService  = 2'b11;
endpackage

// File: rtl/irq_ctrl8_regif.sv
module irq_ctrl8_regif
  import irq_ctrl8_pkg::*;
#(
  parameter int N      = NumLines,
  parameter int DATA_W = DataW,
  localparam int IdxW  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N-1:0]      imr_o,
  output logic [DATA_W-1:0] base_o,
  output logic              aeoi_o,
  output logic              rd_isr_o,
  output logic              eoi_v_o,
  output logic [IdxW-1:0]   eoi_idx_o,
  output logic              init_clr_o
);
  init_st_e          st_q;
  logic [N-1:0]      imr_q;
  logic [DATA_W-1:0] base_q;
  logic              aeoi_q, rd_isr_q, need_casc_q, need_mode_q;

  logic cmd_wr, dat_wr, is_start, is_sel, is_ocw2;
  assign cmd_wr   = wr_en_i & ~addr_i;
  assign dat_wr   = wr_en_i & addr_i;
  assign is_start = cmd_wr & wdata_i[CmdInitBit];
  assign is_sel   = cmd_wr & ~wdata_i[CmdInitBit] & wdata_i[CmdSelBit];
  assign is_ocw2  = cmd_wr & ~wdata_i[CmdInitBit] & ~wdata_i[CmdSelBit];

  assign eoi_v_o    = is_ocw2 && (wdata_i[DATA_W-1 -: 3] == EoiSpecific);
  assign eoi_idx_o  = wdata_i[IdxW-1:0];
  assign init_clr_o = is_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= INIT_IDLE;
      imr_q       <= '1;
      base_q      <= '0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
    end else if (is_start) begin
      st_q        <= INIT_BASE;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
      need_casc_q <= ~wdata_i[StartSnglBit];
      need_mode_q <= wdata_i[StartModeBit];
    end else begin
      if (is_sel) begin
        if (wdata_i[1:0] == SelService)      rd_isr_q <= 1'b1;
        else if (wdata_i[1:0] == SelPending) rd_isr_q <= 1'b0;
      end
      if (dat_wr) begin
        unique case (st_q)
          INIT_IDLE: imr_q <= wdata_i[N-1:0];
          INIT_BASE: begin
            base_q <= wdata_i;
            if (need_casc_q)      st_q <= INIT_CASC;
            else if (need_mode_q) st_q <= INIT_MODE;
            else                  st_q <= INIT_IDLE;
          end
          INIT_CASC: st_q <= need_mode_q ? INIT_MODE : INIT_IDLE;
          INIT_MODE: begin
            aeoi_q <= wdata_i[ModeAeoiBit];
            st_q   <= INIT_IDLE;
          end
          default: st_q <= INIT_IDLE;
        endcase
      end
    end
  end

  assign imr_o    = imr_q;
  assign base_o   = base_q;
  assign aeoi_o   = aeoi_q;
  assign rd_isr_o = rd_isr_q;

  AST_INIT_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != INIT_IDLE) |=> $stable(imr_q)); // R2
endmodule

// File: rtl/irq_ctrl8_prio.sv
module irq_ctrl8_prio #(
  parameter int N     = 8,
  localparam int IdxW = $clog2(N)
) (
  input  logic [N-1:0]    irr_i,
  input  logic [N-1:0]    imr_i,
  input  logic [N-1:0]    isr_i,
  output logic            int_o,
  output logic [IdxW-1:0] win_o
);
  logic [N-1:0]    elig;
  logic            pend_v, isr_v;
  logic [IdxW-1:0] pend_idx, isr_idx;

  assign elig = irr_i & ~imr_i;

  always_comb begin
    pend_v   = 1'b0;
    pend_idx = '0;
    isr_v    = 1'b0;
    isr_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pend_v   = 1'b1;
        pend_idx = IdxW'(i);
      end
      if (isr_i[i]) begin
        isr_v   = 1'b1;
        isr_idx = IdxW'(i);
      end
    end
  end

  assign int_o = pend_v && (!isr_v || (pend_idx < isr_idx));
  assign win_o = pend_idx;
endmodule

// File: rtl/irq_ctrl8_core.sv
module irq_ctrl8_core #(
  parameter int N      = 8,
  parameter int DATA_W = 8,
  localparam int IdxW  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  input  logic              inta_i,
  input  logic [N-1:0]      imr_i,
  input  logic              aeoi_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              eoi_v_i,
  input  logic [IdxW-1:0]   eoi_idx_i,
  input  logic              init_clr_i,
  output logic [N-1:0]      irr_o,
  output logic [N-1:0]      isr_o,
  output logic              int_o,
  output logic [DATA_W-1:0] vector_o,
  output logic              vector_valid_o
);
  logic [N-1:0]      req_q, irr_q, isr_q, rise, hit;
  logic              int_w, ack_fire;
  logic [IdxW-1:0]   win;
  logic [DATA_W-1:0] vec_q;
  logic              vval_q;

  irq_ctrl8_prio #(.N(N)) i_prio (
    .irr_i (irr_q),
    .imr_i (imr_i),
    .isr_i (isr_q),
    .int_o (int_w),
    .win_o (win)
  );

  assign ack_fire = inta_i & int_w;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign rise[g] = req_i[g] & ~req_q[g];
    assign hit[g]  = ack_fire && (win == IdxW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[g] <= 1'b0;
        irr_q[g] <= 1'b0;
        isr_q[g] <= 1'b0;
      end else begin
        req_q[g] <= req_i[g];
        irr_q[g] <= (irr_q[g] | rise[g]) & req_i[g] & ~hit[g];
        if (init_clr_i)
          isr_q[g] <= 1'b0;
        else
          isr_q[g] <= (isr_q[g] & ~(eoi_v_i && (eoi_idx_i == IdxW'(g))))
                    | (hit[g] & ~aeoi_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      vval_q <= 1'b0;
    end else begin
      vval_q <= inta_i;
      if (inta_i)
        vec_q <= base_i + DATA_W'(ack_fire ? win : IdxW'(N - 1));
    end
  end

  assign irr_o          = irr_q;
  assign isr_o          = isr_q;
  assign int_o          = int_w;
  assign vector_o       = vec_q;
  assign vector_valid_o = vval_q;

  AST_INT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_w |-> ((irr_q & ~imr_i) != '0)); // R5
  AST_ACK_SETS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_w && !aeoi_i && !init_clr_i) |=> isr_q[$past(win)]); // R6
  AST_AEOI_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && aeoi_i && !eoi_v_i && !init_clr_i) |=> (isr_q == $past(isr_q))); // R7
  AST_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_v_i && !(ack_fire && win == eoi_idx_i)) |=> !isr_q[$past(eoi_idx_i)]); // R8
  AST_SPUR_KEEP_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_w && !eoi_v_i && !init_clr_i) |=> (isr_q == $past(isr_q))); // R11
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irq_ctrl8_pkg::*;
#(
  parameter int N      = NumLines,
  parameter int DATA_W = DataW,
  localparam int IdxW  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N-1:0]      req_i,
  input  logic              inta_i,
  output logic              int_o,
  output logic [DATA_W-1:0] vector_o,
  output logic              vector_valid_o
);
  logic [N-1:0]      imr, irr, isr;
  logic [DATA_W-1:0] base;
  logic              aeoi, rd_isr, eoi_v, init_clr;
  logic [IdxW-1:0]   eoi_idx;

  irq_ctrl8_regif #(.N(N), .DATA_W(DATA_W)) i_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .imr_o      (imr),
    .base_o     (base),
    .aeoi_o     (aeoi),
    .rd_isr_o   (rd_isr),
    .eoi_v_o    (eoi_v),
    .eoi_idx_o  (eoi_idx),
    .init_clr_o (init_clr)
  );

  irq_ctrl8_core #(.N(N), .DATA_W(DATA_W)) i_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .inta_i         (inta_i),
    .imr_i          (imr),
    .aeoi_i         (aeoi),
    .base_i         (base),
    .eoi_v_i        (eoi_v),
    .eoi_idx_i      (eoi_idx),
    .init_clr_i     (init_clr),
    .irr_o          (irr),
    .isr_o          (isr),
    .int_o          (int_o),
    .vector_o       (vector_o),
    .vector_valid_o (vector_valid_o)
  );

  assign rdata_o = addr_i ? DATA_W'(imr) : DATA_W'(rd_isr ? isr : irr);
endmodule

// File: tb/test_irq_ctrl8.sv
`timescale 1ns/1ps
module test_irq_ctrl8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, req = '0;
  logic [7:0] rdata, vec;
  logic       irq, vval;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  irq_ctrl8 i_irq_ctrl8 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .req_i(req), .inta_i(inta),
    .int_o(irq), .vector_o(vec), .vector_valid_o(vval)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_req(logic [7:0] r);
    @(negedge clk); req = r;
    @(negedge clk);
  endtask

  task automatic ack(string tag, logic [7:0] exp_vec);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    chk({tag, " valid"}, {7'd0, vval}, 8'd1);
    chk({tag, " vector"}, vec, exp_vec);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); chk("R1 pending", v, 8'h00);
    rd(1'b1, v); chk("R1 mask", v, 8'hFF);
    chk("R1 int", {7'd0, irq}, 8'd0);
    chk("R1 valid", {7'd0, vval}, 8'd0);
  endtask

  task automatic t_init();
    logic [7:0] v;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, v); chk("R2 mask untouched", v, 8'hFF);
    wr(1'b1, 8'hA5); rd(1'b1, v); chk("R3 mask A5", v, 8'hA5);
    wr(1'b1, 8'h00); rd(1'b1, v); chk("R3 mask 00", v, 8'h00);
  endtask

  task automatic t_pending();
    logic [7:0] v;
    set_req(8'h08);
    rd(1'b0, v); chk("R4 rise", v, 8'h08);
    chk("R5 int high", {7'd0, irq}, 8'd1);
    set_req(8'h00);
    rd(1'b0, v); chk("R4 drop", v, 8'h00);
    chk("R5 int low", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_nest();
    logic [7:0] v;
    set_req(8'h24);
    chk("R5 int two lines", {7'd0, irq}, 8'd1);
    ack("R6 line2", 8'h22);
    rd(1'b0, v); chk("R6 pending after ack", v, 8'h20);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R10 service sel", v, 8'h04);
    wr(1'b0, 8'h08); rd(1'b0, v); chk("R10 sel kept", v, 8'h04);
    chk("R5 blocked by service", {7'd0, irq}, 8'd0);
    set_req(8'h26);
    chk("R5 higher line", {7'd0, irq}, 8'd1);
    ack("R6 line1", 8'h21);
    rd(1'b0, v); chk("R6 nested service", v, 8'h06);
    wr(1'b0, 8'h61); rd(1'b0, v); chk("R8 specific eoi", v, 8'h04);
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R9 other ocw2 a", v, 8'h04);
    wr(1'b0, 8'h40); rd(1'b0, v); chk("R9 other ocw2 b", v, 8'h04);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    chk("R12 pre int low", {7'd0, irq}, 8'd0);
    @(negedge clk); inta = 1'b1; wr_en = 1'b1; addr = 1'b0; wdata = 8'h62;
    @(negedge clk); inta = 1'b0; wr_en = 1'b0;
    chk("R12 spurious vector", vec, 8'h27);
    rd(1'b0, v); chk("R12 service cleared", v, 8'h00);
    chk("R12 int after", {7'd0, irq}, 8'd1);
    ack("R6 line5", 8'h25);
    rd(1'b0, v); chk("R6 service line5", v, 8'h20);
    wr(1'b0, 8'h65); rd(1'b0, v); chk("R8 eoi line5", v, 8'h00);
    set_req(8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R10 pending sel", v, 8'h00);
  endtask

  task automatic t_spurious();
    logic [7:0] v;
    wr(1'b1, 8'h80);
    ack("R11 idle", 8'h27);
    rd(1'b1, v); chk("R11 mask kept", v, 8'h80);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R11 no service", v, 8'h00);
    set_req(8'h10); set_req(8'h00);
    ack("R11 vanished", 8'h27);
    rd(1'b0, v); chk("R11 no service b", v, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R11 pending kept", v, 8'h00);
  endtask

  task automatic t_aeoi();
    logic [7:0] v;
    set_req(8'h01);
    ack("R6 line0", 8'h20);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R6 service line0", v, 8'h01);
    set_req(8'h00);
    wr(1'b0, 8'h13); wr(1'b1, 8'hFC); wr(1'b1, 8'h02);
    rd(1'b1, v); chk("R2 mask held", v, 8'h80);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R2 service cleared", v, 8'h00);
    set_req(8'h40);
    ack("R6 wrap", 8'h02);
    rd(1'b0, v); chk("R7 no service", v, 8'h00);
    chk("R7 int low", {7'd0, irq}, 8'd0);
    set_req(8'h00);
  endtask

  task automatic t_short_init();
    logic [7:0] v;
    wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h55); wr(1'b1, 8'h3C);
    rd(1'b1, v); chk("R2 three words then mask", v, 8'h3C);
    set_req(8'h01);
    ack("R2 new base", 8'h40);
    rd(1'b0, v); chk("R2 sel reset", v, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R2 aeoi cleared", v, 8'h01);
    set_req(8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_pending();
    t_nest();
    t_same_cycle();
    t_spurious();
    t_aeoi();
    t_short_init();
    finish_run();
  end
endmodule